// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block generates the word address for the sequential port of a 4096 x 16 buffer memory. It keeps a 12-bit pointer. The pointer can be set in four ways: from the data bus after a one-cycle delay, by a jump to one of two preset start addresses, or by stepping forward on each selected access while counting is enabled. The memory array and the random-access port are outside this block.

Each of the two buffers has a start register, an end register and a flow bit, all written through a small register port. When a counting step finds the pointer on a buffer's end address, the flow bit picks the action. With the bit at 1 the pointer returns to that buffer's start. With the bit at 0 it stays on the end address. Two flags show when the pointer sits on either end address. A protocol-error output reports a start strobe that arrives while a direct load is still in progress.

The control path is a two-state machine. In `S_RUN` the pointer is live. In `S_LOAD_WAIT` a captured load value is waiting to be committed. Its transitions are:
- `T_CAPTURE`: from `S_RUN` to `S_LOAD_WAIT` when the load strobe is sampled low.
- `T_RECAPTURE`: stays in `S_LOAD_WAIT` when the load strobe is low again.
- `T_COMMIT`: from `S_LOAD_WAIT` to `S_RUN` when the load strobe is high.
- `T_STAY`: stays in `S_RUN` when there is no load.

Top module: `seq_ptr_top`

## Requirements
- R1: Asserting `rst_n` low clears the pointer to 0 and returns the machine to `S_RUN`. It also resets the configuration: both start registers to 0x000, both end registers to 0xFFF, and both flow bits to 1 (wrap).
- R2: When `ld_n` is sampled low on a rising edge, `din[11:0]` is captured. The pointer does not change at that edge. It takes the captured value at the next edge. If `ld_n` is low again at that next edge, the new value is captured and committed one edge later.
- R3: At the edge where `ld_n` is sampled low, and at the edge that follows, `cnt_en` has no effect on the pointer.
- R4: In `S_RUN` with `ld_n` high, `st1_n` low loads start register 1 at the next edge. Otherwise `st2_n` low loads start register 2. `st1_n` has priority over `st2_n`.
- R5: If `st1_n` or `st2_n` is low while `ld_n` is low or the machine is in `S_LOAD_WAIT`, `proto_err` is high in that cycle and the strobe is ignored.
- R6: With `sel` low and no strobe active, the pointer holds even when `cnt_en` is high.
- R7: With `sel` and `cnt_en` high, no strobe active, and the pointer on neither end address, the pointer increments by one at each edge and wraps from 0xFFF to 0x000.
- R8: A counting step with the pointer on end address 1 sends it to start 1 when flow bit 0 is 1, and holds it when the bit is 0. Otherwise the same rule applies to end address 2 with flow bit 1. Buffer 1 is checked first.
- R9: `eob1` is high exactly when the pointer equals end register 1. `eob2` is high exactly when the pointer equals end register 2.
- R10: `acc_valid` is high when `sel` is high, the machine is in `S_RUN`, and `ld_n` is high. `acc_wr` equals `acc_valid` AND `wr`.
- R11: A write with `cfg_we` high stores `cfg_wdata[11:0]` at the given address: 0 is start 1, 1 is end 1, 2 is start 2, 3 is end 2. Address 4 stores the flow bits from `cfg_wdata[1:0]`, with bit 0 for buffer 1 and bit 1 for buffer 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Sequential port select, active high |
| cnt_en | input | 1 | Count enable, active high |
| wr | input | 1 | Access direction, 1 = write |
| ld_n | input | 1 | Direct address load strobe, active low |
| st1_n | input | 1 | Jump to start 1, active low |
| st2_n | input | 1 | Jump to start 2, active low |
| din | input | 16 | Data bus; bits [11:0] carry the load address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| ptr | output | 12 | Current pointer |
| acc_valid | output | 1 | Access is valid this cycle |
| acc_wr | output | 1 | Valid access is a write |
| eob1 | output | 1 | Pointer is on end address 1 |
| eob2 | output | 1 | Pointer is on end address 2 |
| proto_err | output | 1 | Start strobe arrived during a load |

## Verification
If the machine leaves `S_LOAD_WAIT` at the wrong time, the fault shows one edge after a load. The pointer either keeps its old value or takes the load value too early, and `acc_valid` goes high in a cycle where it should be low. A wrong start, end or flow register shows at the first counting step that reaches an end address. The pointer then lands on the wrong address or fails to stop, and the `eob` flags change with it in the same cycle. A faulty hold register or priority decode shows up after a single edge, because the bench compares the pointer after every edge.

// File: rtl/seq_ptr_pkg.sv
package seq_ptr_pkg;
    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int NBUF = 2;
    localparam int CAW  = 3;

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [0:0] {
        S_RUN       = 1'b0,
        S_LOAD_WAIT = 1'b1
    } ctl_state_e;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_START1 = 3'd2,
        OP_START2 = 3'd3,
        OP_COUNT  = 3'd4
    } ptr_op_e;
endpackage

// File: rtl/seq_ptr_cfg.sv
module seq_ptr_cfg
    import seq_ptr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CAW-1:0]  cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    output addr_t           start_q [NBUF],
    output addr_t           end_q   [NBUF],
    output logic [NBUF-1:0] wrap_q
);
    localparam int FLOW_IDX = 2 * NBUF;

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[b] <= '0;
                end_q[b]   <= '1;
                wrap_q[b]  <= 1'b1;
            end else if (cfg_we) begin
                if (cfg_addr == CAW'(2 * b))
                    start_q[b] <= cfg_wdata[AW-1:0];
                if (cfg_addr == CAW'(2 * b + 1))
                    end_q[b] <= cfg_wdata[AW-1:0];
                if (cfg_addr == CAW'(FLOW_IDX))
                    wrap_q[b] <= cfg_wdata[b];
            end
        end

        assert_cfg_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == CAW'(2 * b)) |=> start_q[b] == $past(cfg_wdata[AW-1:0]))
            else $error("start register write lost");
    end
endmodule

// File: rtl/seq_ptr_ctrl.sv
module seq_ptr_ctrl
    import seq_ptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  logic      cnt_en,
    input  logic      ld_n,
    input  logic      st1_n,
    input  logic      st2_n,
    input  logic [DW-1:0] din,
    output ptr_op_e   op,
    output addr_t     hold_q,
    output logic      acc_valid,
    output logic      proto_err
);
    ctl_state_e state_q, state_d;
    logic       any_start;

    assign any_start = !st1_n || !st2_n;

    // state and hold register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!ld_n)
                hold_q <= din[AW-1:0];
        end
    end

    // transitions and operation decode
    always_comb begin
        state_d = state_q;
        op      = OP_HOLD;
        unique case (state_q)
            S_RUN: begin
                if (!ld_n) begin
                    state_d = S_LOAD_WAIT;      // T_CAPTURE
                    op      = OP_HOLD;
                end else if (!st1_n) begin
                    op = OP_START1;             // T_STAY
                end else if (!st2_n) begin
                    op = OP_START2;
                end else if (sel && cnt_en) begin
                    op = OP_COUNT;
                end
            end
            S_LOAD_WAIT: begin
                op = OP_LOAD;
                if (ld_n) state_d = S_RUN;      // T_COMMIT
                else      state_d = S_LOAD_WAIT; // T_RECAPTURE
            end
            default: begin
                state_d = S_RUN;
                op      = OP_HOLD;
            end
        endcase
    end

    // outputs
    always_comb begin
        proto_err = any_start && (!ld_n || state_q == S_LOAD_WAIT);
        acc_valid = sel && ld_n && (state_q == S_RUN);
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (state_q == S_LOAD_WAIT && hold_q == $past(din[AW-1:0])))
        else $error("load not captured");

    assert_strobe_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (op != OP_START1 && op != OP_START2))
        else $error("start strobe acted during load");

    assert_no_count_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n || state_q == S_LOAD_WAIT) |-> op != OP_COUNT)
        else $error("count during load");
endmodule

// File: rtl/seq_ptr_core.sv
module seq_ptr_core
    import seq_ptr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  ptr_op_e         op,
    input  addr_t           hold_q,
    input  addr_t           start_q [NBUF],
    input  addr_t           end_q   [NBUF],
    input  logic [NBUF-1:0] wrap_q,
    output addr_t           ptr_q,
    output logic [NBUF-1:0] at_end
);
    addr_t step_val;

    for (genvar b = 0; b < NBUF; b++) begin : g_match
        assign at_end[b] = (ptr_q == end_q[b]);
    end

    // count step with end-of-buffer flow control; buffer 0 first
    always_comb begin
        step_val = ptr_q + addr_t'(1);
        for (int b = NBUF - 1; b >= 0; b--) begin
            if (at_end[b])
                step_val = wrap_q[b] ? start_q[b] : ptr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                OP_HOLD:   ptr_q <= ptr_q;
                OP_LOAD:   ptr_q <= hold_q;
                OP_START1: ptr_q <= start_q[0];
                OP_START2: ptr_q <= start_q[1];
                OP_COUNT:  ptr_q <= step_val;
                default:   ptr_q <= ptr_q;
            endcase
        end
    end

    assert_load_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> ptr_q == $past(hold_q))
        else $error("load value not committed");

    assert_start_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_START1) |=> ptr_q == $past(start_q[0]))
        else $error("start 1 jump wrong");

    assert_plain_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_COUNT && at_end == '0) |=> ptr_q == addr_t'($past(ptr_q) + addr_t'(1)))
        else $error("increment wrong");

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(ptr_q))
        else $error("pointer moved on hold");
endmodule

// File: rtl/seq_ptr_top.sv
module seq_ptr_top
    import seq_ptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          cnt_en,
    input  logic          wr,
    input  logic          ld_n,
    input  logic          st1_n,
    input  logic          st2_n,
    input  logic [15:0]   din,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [15:0]   cfg_wdata,
    output logic [11:0]   ptr,
    output logic          acc_valid,
    output logic          acc_wr,
    output logic          eob1,
    output logic          eob2,
    output logic          proto_err
);
    addr_t           start_q [NBUF];
    addr_t           end_q   [NBUF];
    logic [NBUF-1:0] wrap_q;
    addr_t           hold_q;
    addr_t           ptr_q;
    logic [NBUF-1:0] at_end;
    ptr_op_e         op;
    logic            acc_v;

    seq_ptr_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start_q(start_q), .end_q(end_q), .wrap_q(wrap_q)
    );

    seq_ptr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cnt_en(cnt_en), .ld_n(ld_n),
        .st1_n(st1_n), .st2_n(st2_n), .din(din), .op(op), .hold_q(hold_q),
        .acc_valid(acc_v), .proto_err(proto_err)
    );

    seq_ptr_core u_core (
        .clk(clk), .rst_n(rst_n), .op(op), .hold_q(hold_q), .start_q(start_q),
        .end_q(end_q), .wrap_q(wrap_q), .ptr_q(ptr_q), .at_end(at_end)
    );

    assign ptr       = ptr_q;
    assign acc_valid = acc_v;
    assign acc_wr    = acc_v && wr;
    assign eob1      = at_end[0];
    assign eob2      = at_end[1];

    assert_eob_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eob1 && eob2) |-> (end_q[0] == end_q[1]))
        else $error("both end flags with distinct ends");

    assert_wr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> (sel && wr))
        else $error("write access without select");
endmodule

// File: tb/tb_seq_ptr_top.sv
`timescale 1ns/1ps
module tb_seq_ptr_top;
    logic clk = 1'b0;
    logic rst_n, sel, cnt_en, wr, ld_n, st1_n, st2_n, cfg_we;
    logic [15:0] din, cfg_wdata;
    logic [2:0]  cfg_addr;
    logic [11:0] ptr;
    logic acc_valid, acc_wr, eob1, eob2, proto_err;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    seq_ptr_top dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cnt_en(cnt_en), .wr(wr),
        .ld_n(ld_n), .st1_n(st1_n), .st2_n(st2_n), .din(din),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ptr(ptr), .acc_valid(acc_valid), .acc_wr(acc_wr),
        .eob1(eob1), .eob2(eob2), .proto_err(proto_err)
    );

    // [31:27] ld_n st1_n st2_n sel cnt_en, [26:15] din, [14] err,
    // [13:2] pointer after edge, [1] eob1, [0] eob2
    localparam int NV = 21;
    localparam logic [31:0] VEC [NV] = '{
        {5'b01111, 12'h012, 1'b0, 12'h000, 2'b00}, // R2 R3 capture, count ignored
        {5'b11111, 12'h000, 1'b0, 12'h012, 2'b00}, // R2 commit
        {5'b11111, 12'h000, 1'b0, 12'h013, 2'b10}, // R7 R9
        {5'b11111, 12'h000, 1'b0, 12'h010, 2'b00}, // R8 wrap to start 1
        {5'b11010, 12'h000, 1'b0, 12'h800, 2'b00}, // R4 start 2
        {5'b11111, 12'h000, 1'b0, 12'h801, 2'b00},
        {5'b11111, 12'h000, 1'b0, 12'h802, 2'b01}, // R9 eob2
        {5'b11111, 12'h000, 1'b0, 12'h802, 2'b01}, // R8 stop at end 2
        {5'b11101, 12'h000, 1'b0, 12'h802, 2'b01}, // R6 deselected
        {5'b10100, 12'h000, 1'b0, 12'h010, 2'b00}, // R4 start 1
        {5'b01111, 12'hFFE, 1'b0, 12'h010, 2'b00}, // R2
        {5'b10111, 12'h000, 1'b1, 12'hFFE, 2'b00}, // R5 start during wait
        {5'b11111, 12'h000, 1'b0, 12'hFFF, 2'b00},
        {5'b11111, 12'h000, 1'b0, 12'h000, 2'b00}, // R7 wrap to 0
        {5'b10011, 12'h000, 1'b0, 12'h010, 2'b00}, // R4 priority
        {5'b11000, 12'h000, 1'b0, 12'h800, 2'b00},
        {5'b01011, 12'h123, 1'b1, 12'h800, 2'b00}, // R5 with load low
        {5'b11111, 12'h000, 1'b0, 12'h123, 2'b00}, // R3
        {5'b01110, 12'h456, 1'b0, 12'h123, 2'b00},
        {5'b01110, 12'h789, 1'b0, 12'h456, 2'b00}, // R2 recapture
        {5'b11110, 12'h000, 1'b0, 12'h789, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #5;
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sel = 0; cnt_en = 0; wr = 0; ld_n = 1; st1_n = 1; st2_n = 1;
        din = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        repeat (2) @(posedge clk);
        #5 rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state and default config
        check("R1 ptr", 32'(ptr), 32'h000);
        check("R1 eob", {30'd0, eob1, eob2}, 32'd0);
        // R11 register map
        cfg_write(3'd0, 16'hF010);
        cfg_write(3'd1, 16'h0013);
        cfg_write(3'd2, 16'h0800);
        cfg_write(3'd3, 16'h0802);
        cfg_write(3'd4, 16'h0001);
        check("R11 ptr after cfg", 32'(ptr), 32'h000);

        for (int i = 0; i < NV; i++) begin
            {ld_n, st1_n, st2_n, sel, cnt_en} = VEC[i][31:27];
            din = {4'hA, VEC[i][26:15]};
            #3;
            check("R5 proto_err", 32'(proto_err), 32'(VEC[i][14]));
            @(posedge clk); #5;
            check("R2-R9 ptr", 32'(ptr), 32'(VEC[i][13:2]));
            check("R9 eob", {30'd0, eob1, eob2}, 32'(VEC[i][1:0]));
        end

        // R10 access valid and write qualifier
        ld_n = 1; st1_n = 1; st2_n = 1; cnt_en = 0; sel = 1; wr = 1; #3;
        check("R10 valid", {30'd0, acc_valid, acc_wr}, 32'd3);
        wr = 0; #1;
        check("R10 read", {30'd0, acc_valid, acc_wr}, 32'd2);
        ld_n = 0; din = 16'h0055; #1;
        check("R10 load low", 32'(acc_valid), 32'd0);
        @(posedge clk); #5;
        ld_n = 1; #1;
        check("R10 load wait", 32'(acc_valid), 32'd0);
        sel = 0; #1;
        check("R6 deselect", 32'(acc_valid), 32'd0);
        @(posedge clk); #5;
        check("R2 ptr", 32'(ptr), 32'h055);

        // R1 defaults after reset: end 0xFFF, wrap to start 0
        do_reset();
        ld_n = 0; din = 16'h0FFF;
        @(posedge clk); #5; ld_n = 1;
        @(posedge clk); #5;
        check("R1 default eob", {30'd0, eob1, eob2}, 32'd3);
        sel = 1; cnt_en = 1;
        @(posedge clk); #5;
        check("R1 default wrap", 32'(ptr), 32'h000);
        // R8 stop at end 1 when flow bit 0 is clear
        cnt_en = 0;
        cfg_write(3'd1, 16'h0002);
        cfg_write(3'd4, 16'h0000);
        cnt_en = 1;
        repeat (3) @(posedge clk);
        #5;
        check("R8 stop end1", 32'(ptr), 32'h002);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule